// File: doc/BRIEF.md
# Chunked Stride DMA Address Generator

This block produces the per-beat source and destination byte addresses for a single DMA transfer on one channel. A transfer starts from a source base address and a destination base address and covers a given number of bytes, one word per beat. It can run as one contiguous block. It can also be cut into chunks of a common length, with a signed gap added to each address stream between consecutive chunks. The source and destination gaps are independent. A negative gap can make a later chunk start below an earlier one.

Control uses a start/advance handshake. A `start` pulse while idle captures the whole configuration. While `beat_valid` is high, the addresses on the outputs belong to the current beat, and an `adv` pulse consumes that beat. After the last word of a chunk the block spends one cycle applying the gap and presents no beat. After the final beat it returns to idle and pulses `done`. Data movement, bus protocol and arbitration belong to the surrounding engine.

Top module: `stride_addr_gen`

## Requirements
- R1: While reset is asserted, and immediately after it is released, `busy`, `beat_valid`, `last_beat` and `done` are all low.
- R2: A `start` sampled while idle with a non-zero size makes the block busy from the next cycle, with `beat_valid` high and `src_addr`/`dst_addr` equal to the captured base addresses.
- R3: While `beat_valid` is high and `adv` is low, both addresses and `beat_valid` hold. Each accepted beat (`beat_valid` and `adv` high) moves an address whose increment enable is set forward by one 4-byte word.
- R4: When an increment enable is clear, that address equals its base for the whole transfer, and no gap is ever added to it.
- R5: A transfer of S bytes has exactly ceil(S/4) beats. `last_beat` is high on the final beat and only while `beat_valid` is high.
- R6: A chunk length of zero gives one contiguous run of beats with no gap cycles.
- R7: With a non-zero chunk length C, each chunk holds ceil(C/4) beats. After the last beat of every chunk except the final one there is exactly one cycle with `busy` high and `beat_valid` low. In the next beat, each incrementing address equals the previous beat's address plus 4 plus that stream's own signed skip.
- R8: No gap follows the final chunk. When the size is not a whole number of chunks, the final chunk is shorter and holds only the remaining words.
- R9: Skips are two's complement values of ADDR_W bits and address arithmetic wraps modulo 2^ADDR_W. A negative skip larger in magnitude than the chunk length makes chunk k start at base + k·(4·ceil(C/4) + skip), below the previous chunk.
- R10: `start` is ignored while the block is busy.
- R11: `done` is high for exactly one cycle, the cycle after the final beat is accepted, and `busy` is low in that cycle. A `start` with size zero gives `done` in the next cycle with no beats.
- R12: Sizes, chunk length, skips, bases and increment enables are captured at start. Changing these inputs during a transfer does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (accepted only while idle) |
| src_base | input | ADDR_W | Source start byte address |
| dst_base | input | ADDR_W | Destination start byte address |
| xfer_bytes | input | SIZE_W | Total transfer size in bytes |
| chunk_bytes | input | SIZE_W | Common chunk length in bytes, 0 = no chunking |
| src_skip | input | ADDR_W | Signed source gap added between chunks |
| dst_skip | input | ADDR_W | Signed destination gap added between chunks |
| src_inc | input | 1 | Source address increment enable |
| dst_inc | input | 1 | Destination address increment enable |
| adv | input | 1 | Consume the current beat |
| busy | output | 1 | Transfer in progress |
| beat_valid | output | 1 | Addresses on the outputs form a beat |
| src_addr | output | ADDR_W | Source address of the current beat |
| dst_addr | output | ADDR_W | Destination address of the current beat |
| last_beat | output | 1 | Current beat is the final one |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The bench uses the default parameters: ADDR_W = 32, SIZE_W = 16 and a 4-byte word. With 32-bit addresses, bases near the top of the address space combined with negative skips exercise wraparound of the gap arithmetic. A 16-bit size is wide enough to reach both short final chunks and chunks longer than the whole transfer.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [1:0] {
        SG_IDLE = 2'd0,
        SG_BEAT = 2'd1,
        SG_GAP  = 2'd2
    } sag_state_e;

    typedef struct packed {
        sag_state_e state;
        logic       done;
    } sag_ctrl_t;

endpackage

// File: rtl/sag_beat_count.sv
module sag_beat_count #(
    parameter int SIZE_W     = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] size_in,
    input  logic [SIZE_W-1:0] chunk_in,
    input  logic              take,
    output logic              last_xfer,
    output logic              last_chunk,
    output logic              chunk_on
);
    localparam logic [SIZE_W-1:0] WB = SIZE_W'(WORD_BYTES);

    typedef struct packed {
        logic [SIZE_W-1:0] rem;
        logic [SIZE_W-1:0] crem;
        logic [SIZE_W-1:0] chunk;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    assign last_xfer  = (cnt_q.rem <= WB);
    assign last_chunk = (cnt_q.crem <= WB);
    assign chunk_on   = (cnt_q.chunk != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.rem   = size_in;
            cnt_d.crem  = chunk_in;
            cnt_d.chunk = chunk_in;
        end else if (take) begin
            if (!last_xfer) begin
                cnt_d.rem = cnt_q.rem - WB;
            end
            if (chunk_on) begin
                cnt_d.crem = last_chunk ? cnt_q.chunk : (cnt_q.crem - WB);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sag_addr_lane.sv
module sag_addr_lane #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] skip_in,
    input  logic              inc_in,
    input  logic              step,
    input  logic              skip_now,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] skip;
        logic              inc;
    } lane_t;

    lane_t ln_d, ln_q;

    assign addr = ln_q.addr;

    always_comb begin
        ln_d = ln_q;
        if (load) begin
            ln_d.addr = base_in;
            ln_d.skip = skip_in;
            ln_d.inc  = inc_in;
        end else if (ln_q.inc) begin
            if (step) begin
                ln_d.addr = ln_q.addr + STEP;
            end else if (skip_now) begin
                ln_d.addr = ln_q.addr + ln_q.skip;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end
endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
    import sag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [SIZE_W-1:0] xfer_bytes,
    input  logic [SIZE_W-1:0] chunk_bytes,
    input  logic [ADDR_W-1:0] src_skip,
    input  logic [ADDR_W-1:0] dst_skip,
    input  logic              src_inc,
    input  logic              dst_inc,
    input  logic              adv,
    output logic              busy,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              last_beat,
    output logic              done
);
    localparam int NUM_LANES = 2;

    sag_ctrl_t ctl_d, ctl_q;

    logic start_acc, size_zero, take, gap_go;
    logic last_xfer, last_chunk, chunk_on;

    logic [NUM_LANES-1:0][ADDR_W-1:0] lane_base, lane_skip, lane_addr;
    logic [NUM_LANES-1:0]             lane_inc;

    assign start_acc  = start && (ctl_q.state == SG_IDLE);
    assign size_zero  = (xfer_bytes == '0);
    assign beat_valid = (ctl_q.state == SG_BEAT);
    assign busy       = (ctl_q.state != SG_IDLE);
    assign take       = beat_valid && adv;
    assign gap_go     = take && !last_xfer && chunk_on && last_chunk;
    assign last_beat  = beat_valid && last_xfer;
    assign done       = ctl_q.done;

    assign lane_base = {dst_base, src_base};
    assign lane_skip = {dst_skip, src_skip};
    assign lane_inc  = {dst_inc, src_inc};
    assign src_addr  = lane_addr[0];
    assign dst_addr  = lane_addr[1];

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.state)
            SG_IDLE: begin
                if (start_acc) begin
                    if (size_zero) ctl_d.done  = 1'b1;
                    else           ctl_d.state = SG_BEAT;
                end
            end
            SG_BEAT: begin
                if (take && last_xfer) begin
                    ctl_d.state = SG_IDLE;
                    ctl_d.done  = 1'b1;
                end else if (gap_go) begin
                    ctl_d.state = SG_GAP;
                end
            end
            SG_GAP: begin
                ctl_d.state = SG_BEAT;
            end
            default: begin
                ctl_d.state = SG_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: SG_IDLE, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sag_beat_count #(
        .SIZE_W    (SIZE_W),
        .WORD_BYTES(WORD_BYTES)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_acc),
        .size_in   (xfer_bytes),
        .chunk_in  (chunk_bytes),
        .take      (take),
        .last_xfer (last_xfer),
        .last_chunk(last_chunk),
        .chunk_on  (chunk_on)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        sag_addr_lane #(
            .ADDR_W    (ADDR_W),
            .WORD_BYTES(WORD_BYTES)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (start_acc),
            .base_in (lane_base[g]),
            .skip_in (lane_skip[g]),
            .inc_in  (lane_inc[g]),
            .step    (take),
            .skip_now(ctl_q.state == SG_GAP),
            .addr    (lane_addr[g])
        );
    end
endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 16,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] src_base,
    input logic [ADDR_W-1:0] dst_base,
    input logic [SIZE_W-1:0] xfer_bytes,
    input logic [ADDR_W-1:0] src_skip,
    input logic [ADDR_W-1:0] dst_skip,
    input logic              src_inc,
    input logic              dst_inc,
    input logic              adv,
    input logic              busy,
    input logic              beat_valid,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              last_beat,
    input logic              done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] sb_c, db_c, ss_c, ds_c;
    logic              si_c, di_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sb_c <= '0; db_c <= '0; ss_c <= '0; ds_c <= '0;
            si_c <= 1'b0; di_c <= 1'b0;
        end else if (start && !busy) begin
            sb_c <= src_base; db_c <= dst_base;
            ss_c <= src_skip; ds_c <= dst_skip;
            si_c <= src_inc;  di_c <= dst_inc;
        end
    end

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && xfer_bytes != '0) |=>
        (beat_valid && src_addr == $past(src_base) && dst_addr == $past(dst_base)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !adv) |=> (beat_valid && $stable(src_addr) && $stable(dst_addr)));

    // R3
    src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && adv && !last_beat && si_c) |=> (src_addr == $past(src_addr) + STEP));

    // R3
    dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && adv && !last_beat && di_c) |=> (dst_addr == $past(dst_addr) + STEP));

    // R4
    src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !si_c) |-> (src_addr == sb_c));

    // R4
    dst_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !di_c) |-> (dst_addr == db_c));

    // R5
    last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> beat_valid);

    // R7
    src_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_valid && si_c) |=> (beat_valid && src_addr == $past(src_addr) + ss_c));

    // R7
    dst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_valid && di_c) |=> (beat_valid && dst_addr == $past(dst_addr) + ds_c));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(beat_valid && adv && last_beat)) |=> busy);

    // R11
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && adv && last_beat) |=> (done && !busy));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind stride_addr_gen sag_chk #(
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W),
    .WORD_BYTES(WORD_BYTES)
) u_sag_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_base  (src_base),
    .dst_base  (dst_base),
    .xfer_bytes(xfer_bytes),
    .src_skip  (src_skip),
    .dst_skip  (dst_skip),
    .src_inc   (src_inc),
    .dst_inc   (dst_inc),
    .adv       (adv),
    .busy      (busy),
    .beat_valid(beat_valid),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .last_beat (last_beat),
    .done      (done)
);

// File: tb/stride_addr_gen_bench.sv
module stride_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_base = '0, dst_base = '0, src_skip = '0, dst_skip = '0;
    logic [15:0] xfer_bytes = '0, chunk_bytes = '0;
    logic        src_inc = 1'b0, dst_inc = 1'b0, adv = 1'b0;
    logic        busy, beat_valid, last_beat, done;
    logic [31:0] src_addr, dst_addr;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    stride_addr_gen u_stride_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_base(src_base), .dst_base(dst_base),
        .xfer_bytes(xfer_bytes), .chunk_bytes(chunk_bytes),
        .src_skip(src_skip), .dst_skip(dst_skip),
        .src_inc(src_inc), .dst_inc(dst_inc), .adv(adv),
        .busy(busy), .beat_valid(beat_valid),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .last_beat(last_beat), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(logic [31:0] base, int skip, bit inc, int wpc, int i);
        int k, j;
        if (!inc) return base;
        if (wpc == 0) return base + 32'(i * 4);
        k = i / wpc;
        j = i % wpc;
        return base + 32'(k * (wpc * 4 + skip)) + 32'(j * 4);
    endfunction

    task automatic xfer(input logic [31:0] sb, input logic [31:0] db, input int size, input int chunk,
                        input int ss, input int ds, input bit si, input bit di, input int adv_pct);
        int  n, wpc, i;
        bit  gap, fin, first, a;
        n   = (size + 3) / 4;
        wpc = (chunk == 0) ? 0 : (chunk + 3) / 4;
        @(negedge clk);
        start = 1'b1; src_base = sb; dst_base = db;
        xfer_bytes = 16'(size); chunk_bytes = 16'(chunk);
        src_skip = 32'(ss); dst_skip = 32'(ds); src_inc = si; dst_inc = di; adv = 1'b0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            // R11 size zero
            chk(done && !busy, "R11 zero-size done", {30'b0, done, busy}, 32'h2);
            @(posedge clk); @(negedge clk);
            chk(!done && !busy, "R11 done single cycle", {31'b0, done}, 32'h0);
            return;
        end
        i = 0; gap = 0; fin = 0; first = 1;
        while (!fin) begin
            if (gap) begin
                chk(busy && !beat_valid, "R7 gap cycle", {30'b0, busy, beat_valid}, 32'h2);
                gap = 0;
                adv = 1'($urandom_range(1));
            end else begin
                chk(beat_valid && busy, "R2 beat present", {31'b0, beat_valid}, 32'h1);
                chk(src_addr == exp_addr(sb, ss, si, wpc, i),
                    si ? (wpc != 0 ? "R7 src addr" : "R3 src addr") : "R4 src fixed",
                    src_addr, exp_addr(sb, ss, si, wpc, i));
                chk(dst_addr == exp_addr(db, ds, di, wpc, i),
                    di ? (wpc != 0 ? "R9 dst addr" : "R6 dst addr") : "R4 dst fixed",
                    dst_addr, exp_addr(db, ds, di, wpc, i));
                chk(last_beat == (i == n - 1), "R5 last beat", {31'b0, last_beat}, {31'b0, (i == n - 1)});
                a = ($urandom_range(99) < adv_pct);
                adv = a;
                if (a) begin
                    if (i == n - 1) fin = 1;
                    else if (wpc != 0 && (i % wpc) == wpc - 1) gap = 1;  // R8: never after final chunk
                    i++;
                end
            end
            if (first) begin
                // R10 start while busy, R12 inputs change mid-transfer
                start = 1'b1; src_base = ~sb; dst_base = ~db;
                xfer_bytes = 16'h0040; chunk_bytes = 16'h0008;
                src_skip = 32'h100; dst_skip = 32'hFFFF_FF00; src_inc = ~si; dst_inc = ~di;
                first = 0;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0; adv = 1'b0;
        chk(done && !busy && !beat_valid, "R11 done after last", {29'b0, done, busy, beat_valid}, 32'h4);
        @(posedge clk); @(negedge clk);
        chk(!done && !busy, "R11 done one cycle", {31'b0, done}, 32'h0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_run++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1
        chk(!busy && !beat_valid && !done && !last_beat, "R1 in reset",
            {28'b0, busy, beat_valid, done, last_beat}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !beat_valid && !done && !last_beat, "R1 after reset",
            {28'b0, busy, beat_valid, done, last_beat}, 32'h0);

        // directed corners
        xfer(32'h1000, 32'h8000, 0, 16, 8, 8, 1, 1, 100);                  // R11 size zero
        xfer(32'h1000, 32'h8000, 64, 0, 100, -100, 1, 1, 70);              // R6 contiguous
        xfer(32'h2000, 32'h9000, 10, 0, 0, 0, 1, 1, 100);                  // R5 ceil rounding
        xfer(32'h3000, 32'hA000, 40, 16, 32, 8, 1, 1, 60);                 // R7 R8 short final chunk
        xfer(32'h4000, 32'hB000, 48, 16, -48, -16, 1, 1, 80);              // R9 negative beyond chunk
        xfer(32'h0000_0008, 32'hFFFF_FFF0, 32, 8, -64, 12, 1, 1, 100);     // R9 wraparound
        xfer(32'h5000, 32'hC000, 24, 8, 40, 40, 0, 1, 50);                 // R4 src fixed
        xfer(32'h6000, 32'hD000, 24, 8, 40, 40, 1, 0, 50);                 // R4 dst fixed
        xfer(32'h7000, 32'hE000, 16, 64, 4, 4, 1, 1, 100);                 // R8 chunk longer than size
        xfer(32'h7100, 32'hE100, 4, 4, 4, 4, 1, 1, 30);                    // R5 single beat, R3 hold

        // constrained random
        for (int t = 0; t < 60; t++) begin
            int sz, ch;
            sz = 4 * $urandom_range(40);
            ch = ($urandom_range(3) == 0) ? 0 : 4 * $urandom_range(1, 10);
            xfer($urandom(), $urandom(), sz, ch,
                 4 * ($urandom_range(128) - 64), 4 * ($urandom_range(128) - 64),
                 1'($urandom_range(4) != 0), 1'($urandom_range(4) != 0),
                 30 + $urandom_range(70));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule